// File: doc/BRIEF.md
# Bounded-Pointer Coherence Directory

This block keeps coherence state for a set of memory blocks. It does not keep a presence bit for every cache. Each block's entry holds a fixed number of sharer slots. A slot holds a cache ID and a valid flag. The entry also has an exclusive-owner flag and a round-robin victim index. Because of this, the entry size depends on the slot count and not on the number of caches.

A requester presents a request type (read or write), its cache ID and a block index. The directory accepts only one request at a time.

- **Read:** the directory records the requester as a sharer. If every slot is already taken by other caches, the sharer in the slot named by the victim index gets an invalidate. Once it acknowledges, that slot is reused for the requester.
- **Write:** the directory invalidates every other recorded sharer, one at a time. It then leaves the writer as the only sharer, with the exclusive flag set.

Completion is signalled by a one-cycle done pulse. Data movement is handled elsewhere.

Top module: `lptr_directory`

## Requirements
- R1: After reset, `req_ready` is 1, while `inv_valid` and `done` are 0. Every entry starts with no valid slots, exclusive flag 0 and victim index 0.
- R2: A read that needs no eviction raises `done` on the second clock after the accepting edge, without any invalidate. A needless eviction is a read whose requester is absent and which finds a free slot. The requester is placed in the lowest-numbered free slot.
- R3: A read from a cache already held in a valid slot leaves the entry unchanged and issues no invalidate. It completes with the same latency as in R2.
- R4: A read by an absent cache when all slots are valid invalidates the ID in the slot named by the victim index. After the eviction the victim index advances by one, wrapping from the last slot to slot 0.
- R5: `inv_valid` and `inv_id` hold steady until `inv_ack` is sampled high, and `done` stays low during that time. An evicted slot takes the requester's ID only in the cycle the ack is sampled.
- R6: A write invalidates each valid slot whose ID differs from the writer, in ascending slot order, one invalidate at a time, each waiting for its ack. The requester itself is never invalidated.
- R7: After a write, the entry holds only the writer, in slot 0, with the exclusive flag set. A following read by another cache clears the flag and takes a free slot with no eviction.
- R8: Entries of different block indices are independent.
- R9: `req_ready` is low from the accepting edge until the request completes, and `req_valid` is ignored while `req_ready` is low.
- R10: `done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory idle, request taken on this edge if valid |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_id | input | $clog2(NUM_CACHES) | Requesting cache ID |
| req_blk | input | $clog2(NUM_BLOCKS) | Block index |
| inv_valid | output | 1 | Invalidate pending for `inv_id` |
| inv_id | output | $clog2(NUM_CACHES) | Target cache of the invalidate |
| inv_ack | input | 1 | Invalidate acknowledged by the target |
| done | output | 1 | One-cycle pulse: request completed |

## Verification
The hardest state to reach is a full entry whose victim index points at a slot other than 0. Reaching it takes a series of reads from distinct caches to fill the slots, then an eviction to advance the index. A write from a cache that sits in a middle slot must then skip itself. The stimulus table drives one block through exactly that history, with acknowledgement delays of zero to two cycles. It then checks the order of the invalidate targets.

A directed case raises a request while an eviction waits for its ack. It then proves through a later write that the request was dropped.

// File: rtl/lptr_dir_pkg.sv
package lptr_dir_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EVAL,
      ST_RD_INV,
      ST_WR_SCAN,
      ST_WR_INV
   } dir_state_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/lptr_dir_store.sv
module lptr_dir_store #(
   parameter int unsigned NB  = 16,
   parameter int unsigned P   = 2,
   parameter int unsigned IDW = 3,
   parameter int unsigned VW  = 1,
   localparam int unsigned BW = lptr_dir_pkg::idx_width(NB)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [BW-1:0]           blk,
   input  logic                    wr_en,
   input  logic [P-1:0][IDW-1:0]   wr_ids,
   input  logic [P-1:0]            wr_vld,
   input  logic                    wr_excl,
   input  logic [VW-1:0]           wr_vic,
   output logic [P-1:0][IDW-1:0]   rd_ids,
   output logic [P-1:0]            rd_vld,
   output logic                    rd_excl,
   output logic [VW-1:0]           rd_vic
);

   logic [P-1:0][IDW-1:0] ids_q  [NB];
   logic [P-1:0]          vld_q  [NB];
   logic                  excl_q [NB];
   logic [VW-1:0]         vic_q  [NB];

   for (genvar b = 0; b < NB; b++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ids_q[b]  <= '0;
            vld_q[b]  <= '0;
            excl_q[b] <= 1'b0;
            vic_q[b]  <= '0;
         end else if (wr_en && blk == BW'(b)) begin
            ids_q[b]  <= wr_ids;
            vld_q[b]  <= wr_vld;
            excl_q[b] <= wr_excl;
            vic_q[b]  <= wr_vic;
         end
      end
   end

   assign rd_ids  = ids_q[blk];
   assign rd_vld  = vld_q[blk];
   assign rd_excl = excl_q[blk];
   assign rd_vic  = vic_q[blk];

endmodule

// File: rtl/lptr_dir_match.sv
module lptr_dir_match #(
   parameter int unsigned P   = 2,
   parameter int unsigned IDW = 3,
   parameter int unsigned VW  = 1
) (
   input  logic [P-1:0][IDW-1:0] ids,
   input  logic [P-1:0]          vld,
   input  logic [IDW-1:0]        req_id,
   output logic                  hit,
   output logic                  free_any,
   output logic [VW-1:0]         free_idx
);

   logic [P-1:0] hit_vec;

   for (genvar s = 0; s < P; s++) begin : g_slot
      assign hit_vec[s] = vld[s] && (ids[s] == req_id);
   end

   assign hit      = |hit_vec;
   assign free_any = ~&vld;

   always_comb begin
      free_idx = '0;
      for (int s = P - 1; s >= 0; s--) begin
         if (!vld[s]) free_idx = VW'(s);
      end
   end

endmodule

// File: rtl/lptr_directory.sv
module lptr_directory #(
   parameter int unsigned NUM_CACHES = 8,
   parameter int unsigned PTRS       = 2,
   parameter int unsigned NUM_BLOCKS = 16,
   localparam int unsigned IDW = lptr_dir_pkg::idx_width(NUM_CACHES),
   localparam int unsigned BW  = lptr_dir_pkg::idx_width(NUM_BLOCKS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic           req_write,
   input  logic [IDW-1:0] req_id,
   input  logic [BW-1:0]  req_blk,
   output logic           inv_valid,
   output logic [IDW-1:0] inv_id,
   input  logic           inv_ack,
   output logic           done
);
   import lptr_dir_pkg::*;

   localparam int unsigned VW = idx_width(PTRS);
   localparam logic [VW-1:0] VMAX = VW'(PTRS - 1);

   if (PTRS < 1 || PTRS > NUM_CACHES) begin : g_bad_ptrs
      $error("PTRS must lie between 1 and NUM_CACHES");
   end
   if (NUM_CACHES < 2) begin : g_bad_caches
      $error("NUM_CACHES must be at least 2");
   end
   if ((1 << BW) != NUM_BLOCKS) begin : g_bad_blocks
      $error("NUM_BLOCKS must be a power of two");
   end

   dir_state_e     state;
   logic           r_write;
   logic [IDW-1:0] r_id;
   logic [BW-1:0]  r_blk;
   logic [VW-1:0]  scan_idx;
   logic [IDW-1:0] inv_id_q;
   logic           done_q;

   logic [PTRS-1:0][IDW-1:0] rd_ids, n_ids;
   logic [PTRS-1:0]          rd_vld, n_vld;
   logic                     rd_excl, n_excl;
   logic [VW-1:0]            rd_vic, n_vic, vic_next;
   logic                     wr_en;
   logic                     hit, free_any;
   logic [VW-1:0]            free_idx;
   logic                     need_inv, last_slot;

   lptr_dir_store #(.NB(NUM_BLOCKS), .P(PTRS), .IDW(IDW), .VW(VW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .blk     (r_blk),
      .wr_en   (wr_en),
      .wr_ids  (n_ids),
      .wr_vld  (n_vld),
      .wr_excl (n_excl),
      .wr_vic  (n_vic),
      .rd_ids  (rd_ids),
      .rd_vld  (rd_vld),
      .rd_excl (rd_excl),
      .rd_vic  (rd_vic)
   );

   lptr_dir_match #(.P(PTRS), .IDW(IDW), .VW(VW)) u_match (
      .ids      (rd_ids),
      .vld      (rd_vld),
      .req_id   (r_id),
      .hit      (hit),
      .free_any (free_any),
      .free_idx (free_idx)
   );

   assign vic_next  = (rd_vic == VMAX) ? '0 : rd_vic + 1'b1;
   assign need_inv  = rd_vld[scan_idx] && (rd_ids[scan_idx] != r_id);
   assign last_slot = (scan_idx == VMAX);

   // Next-entry computation
   always_comb begin
      wr_en  = 1'b0;
      n_ids  = rd_ids;
      n_vld  = rd_vld;
      n_excl = rd_excl;
      n_vic  = rd_vic;
      unique case (state)
         ST_EVAL: begin
            if (!r_write && !hit && free_any) begin
               wr_en            = 1'b1;
               n_ids[free_idx]  = r_id;
               n_vld[free_idx]  = 1'b1;
               n_excl           = 1'b0;
            end
         end
         ST_RD_INV: begin
            if (inv_ack) begin
               wr_en          = 1'b1;
               n_ids[rd_vic]  = r_id;
               n_vld[rd_vic]  = 1'b1;
               n_excl         = 1'b0;
               n_vic          = vic_next;
            end
         end
         ST_WR_SCAN, ST_WR_INV: begin
            if ((state == ST_WR_SCAN && !need_inv && last_slot) ||
                (state == ST_WR_INV && inv_ack && last_slot)) begin
               wr_en    = 1'b1;
               n_ids    = '0;
               n_ids[0] = r_id;
               n_vld    = '0;
               n_vld[0] = 1'b1;
               n_excl   = 1'b1;
            end
         end
         default: ;
      endcase
   end

   // Request sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         r_write  <= 1'b0;
         r_id     <= '0;
         r_blk    <= '0;
         scan_idx <= '0;
         inv_id_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  r_write <= req_write;
                  r_id    <= req_id;
                  r_blk   <= req_blk;
                  state   <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               if (r_write) begin
                  scan_idx <= '0;
                  state    <= ST_WR_SCAN;
               end else if (hit || free_any) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  inv_id_q <= rd_ids[rd_vic];
                  state    <= ST_RD_INV;
               end
            end
            ST_RD_INV: begin
               if (inv_ack) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            ST_WR_SCAN: begin
               if (need_inv) begin
                  inv_id_q <= rd_ids[scan_idx];
                  state    <= ST_WR_INV;
               end else if (last_slot) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  scan_idx <= scan_idx + 1'b1;
               end
            end
            ST_WR_INV: begin
               if (inv_ack) begin
                  if (last_slot) begin
                     done_q <= 1'b1;
                     state  <= ST_IDLE;
                  end else begin
                     scan_idx <= scan_idx + 1'b1;
                     state    <= ST_WR_SCAN;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign inv_valid = (state == ST_RD_INV) || (state == ST_WR_INV);
   assign inv_id    = inv_id_q;
   assign done      = done_q;

endmodule

// File: rtl/lptr_directory_chk.sv
module lptr_directory_chk #(
   parameter int unsigned IDW = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           req_valid,
   input logic           req_ready,
   input logic [IDW-1:0] req_id,
   input logic           inv_valid,
   input logic [IDW-1:0] inv_id,
   input logic           inv_ack,
   input logic           done
);

   logic [IDW-1:0] held_id;

   always_ff @(posedge clk) begin
      if (!rst_n)                     held_id <= '0;
      else if (req_valid && req_ready) held_id <= req_id;
   end

   assert_inv_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid && !inv_ack |=> inv_valid && $stable(inv_id));

   assert_no_done_during_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> !done);

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   assert_inv_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> !req_ready);

   assert_no_self_inv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> inv_id != held_id);

endmodule

bind lptr_directory lptr_directory_chk #(.IDW(IDW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_id    (req_id),
   .inv_valid (inv_valid),
   .inv_id    (inv_id),
   .inv_ack   (inv_ack),
   .done      (done)
);

// File: tb/lptr_directory_tb.sv
module lptr_directory_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic       req_write = 1'b0;
   logic [2:0] req_id = '0;
   logic [3:0] req_blk = '0;
   logic       inv_valid;
   logic [2:0] inv_id;
   logic       inv_ack = 1'b0;
   logic       done;

   int checks = 0;
   int errors = 0;
   bit finished_all = 1'b0;

   int         got_n;
   logic [2:0] got_ids [4];
   int         got_lat;

   always #4 clk = ~clk;

   lptr_directory #(.NUM_CACHES(8), .PTRS(2), .NUM_BLOCKS(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_id(req_id), .req_blk(req_blk),
      .inv_valid(inv_valid), .inv_id(inv_id), .inv_ack(inv_ack), .done(done)
   );

   // {write, id[2:0], blk[3:0], n_inv[1:0], exp0[2:0], exp1[2:0]}
   localparam int NV = 14;
   localparam logic [15:0] VEC [NV] = '{
      {1'b0, 3'd1, 4'd3, 2'd0, 3'd0, 3'd0},
      {1'b0, 3'd2, 4'd3, 2'd0, 3'd0, 3'd0},
      {1'b0, 3'd1, 4'd3, 2'd0, 3'd0, 3'd0},
      {1'b0, 3'd4, 4'd3, 2'd1, 3'd1, 3'd0},
      {1'b0, 3'd5, 4'd3, 2'd1, 3'd2, 3'd0},
      {1'b1, 3'd5, 4'd3, 2'd1, 3'd4, 3'd0},
      {1'b0, 3'd6, 4'd3, 2'd0, 3'd0, 3'd0},
      {1'b1, 3'd7, 4'd3, 2'd2, 3'd5, 3'd6},
      {1'b1, 3'd7, 4'd3, 2'd0, 3'd0, 3'd0},
      {1'b0, 3'd0, 4'd5, 2'd0, 3'd0, 3'd0},
      {1'b1, 3'd2, 4'd5, 2'd1, 3'd0, 3'd0},
      {1'b0, 3'd3, 4'd3, 2'd0, 3'd0, 3'd0},
      {1'b0, 3'd4, 4'd3, 2'd1, 3'd7, 3'd0},
      {1'b1, 3'd3, 4'd3, 2'd1, 3'd4, 3'd0}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Issue one request, acknowledge invalidates after ack_dly cycles,
   // optionally raise a stray request while an invalidate is pending.
   task automatic run_req(input bit wr, input logic [2:0] id, input logic [3:0] blk,
                          input int ack_dly, input bit inject);
      int  cyc;
      bit  fin;
      logic [2:0] tgt;
      got_n = 0;
      got_lat = -1;
      @(negedge clk);
      check(req_ready == 1'b1, "R9", "ready before request", int'(req_ready), 1);
      req_valid = 1'b1; req_write = wr; req_id = id; req_blk = blk;
      @(posedge clk);
      cyc = 0;
      fin = 1'b0;
      while (!fin && cyc < 200) begin
         @(negedge clk);
         req_valid = 1'b0;
         cyc++;
         if (done) begin
            fin = 1'b1;
            got_lat = cyc;
         end else if (inv_valid) begin
            tgt = inv_id;
            if (got_n < 4) got_ids[got_n] = tgt;
            got_n++;
            for (int k = 0; k < ack_dly; k++) begin
               if (inject && k == 0) begin
                  check(req_ready == 1'b0, "R9", "ready while busy", int'(req_ready), 0);
                  req_valid = 1'b1; req_write = 1'b1; req_id = 3'd6; req_blk = 4'd9;
               end
               @(negedge clk);
               req_valid = 1'b0;
               cyc++;
               check(inv_valid && inv_id == tgt && !done, "R5", "invalidate held",
                     int'(inv_id), int'(tgt));
            end
            inv_ack = 1'b1;
            @(negedge clk);
            inv_ack = 1'b0;
            cyc++;
            if (done) begin
               fin = 1'b1;
               got_lat = cyc;
            end
         end
      end
      check(fin, "R10", "request completed", int'(fin), 1);
      @(negedge clk);
      check(done == 1'b0, "R10", "done single cycle", int'(done), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1", "reset ready", int'(req_ready), 1);
      check(inv_valid == 1'b0, "R1", "reset inv_valid", int'(inv_valid), 0);
      check(done == 1'b0, "R1", "reset done", int'(done), 0);

      for (int i = 0; i < NV; i++) begin
         logic [15:0] v;
         string rq;
         v = VEC[i];
         rq = v[15] ? "R6" : "R4";
         run_req(v[15], v[14:12], v[11:8], i % 3, 1'b0);
         check(got_n == int'(v[7:6]), rq, $sformatf("vec %0d invalidate count", i),
               got_n, int'(v[7:6]));
         if (v[7:6] >= 2'd1 && got_n >= 1)
            check(got_ids[0] == v[5:3], rq, $sformatf("vec %0d first target", i),
                  int'(got_ids[0]), int'(v[5:3]));
         if (v[7:6] >= 2'd2 && got_n >= 2)
            check(got_ids[1] == v[2:0], rq, $sformatf("vec %0d second target", i),
                  int'(got_ids[1]), int'(v[2:0]));
         if (!v[15] && v[7:6] == 2'd0)
            check(got_lat == 2, (i == 2) ? "R3" : "R2", $sformatf("vec %0d read latency", i),
                  got_lat, 2);
      end

      // R1: untouched block holds no sharers, so a write invalidates nothing
      run_req(1'b1, 3'd3, 4'd12, 0, 1'b0);
      check(got_n == 0, "R1", "fresh block write", got_n, 0);

      // R7: read after write takes a free slot, no eviction
      run_req(1'b0, 3'd1, 4'd12, 0, 1'b0);
      check(got_n == 0 && got_lat == 2, "R7", "reader after writer", got_n, 0);

      // R9: stray request during an eviction is dropped
      run_req(1'b0, 3'd1, 4'd7, 0, 1'b0);
      run_req(1'b0, 3'd2, 4'd7, 0, 1'b0);
      run_req(1'b0, 3'd3, 4'd7, 2, 1'b1);
      check(got_n == 1 && got_ids[0] == 3'd1, "R4", "eviction slot 0 on block 7",
            int'(got_ids[0]), 1);
      run_req(1'b1, 3'd5, 4'd9, 0, 1'b0);
      check(got_n == 0, "R9", "block 9 untouched by dropped request", got_n, 0);

      // R8: block 7 state unaffected by block 9 traffic
      run_req(1'b1, 3'd2, 4'd7, 1, 1'b0);
      check(got_n == 1 && got_ids[0] == 3'd3, "R8", "block 7 write targets",
            int'(got_ids[0]), 3);

      finished_all = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished_all) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule